// File: doc/BRIEF.md
# Wide-Register Upper-Half State Tracker

This block models the bookkeeping a vector unit performs on the upper halves of its wide registers when full-width wide-vector instructions, half-width wide-encoded instructions and legacy narrow instructions are mixed in one stream. It accepts one decoded instruction class per handshake, moves a three-state machine, and holds two copies of the upper halves: the live copy and a save area. When the machine must set the upper halves aside, or bring them back, it stalls for a parameterised number of cycles and holds its ready output low for the whole stall.

The three states are CLEAN, DIRTY and PRESERVED. The transitions are as follows. A full-width instruction moves CLEAN to DIRTY. A legacy instruction moves DIRTY to PRESERVED through a save stall. A full-width instruction moves PRESERVED to DIRTY through a restore stall. A zero-upper or zero-all instruction moves CLEAN or DIRTY to CLEAN with no stall, and moves PRESERVED to CLEAN through a restore stall. All other class and state pairs leave the state unchanged.

The block reports the current state and a count of stalled cycles. It offers a read port onto the upper halves. A zero-all instruction also clears the lower halves, which are held elsewhere, so the block issues a write strobe for them.

Top module: `wide_upper_tracker`

## Requirements
- R1: After synchronous reset, `mode_state` is 0 (CLEAN), `in_ready` is 1, `stall_cycles` is 0, and every upper half reads as zero.
- R2: A full-width instruction (class 2) accepted in CLEAN (0) or DIRTY (1) writes `in_upper` into the upper half of register `in_dst`. The state becomes DIRTY and there is no stall.
- R3: A half-width wide instruction (class 1) never changes the state, never stalls, and leaves the upper halves untouched.
- R4: A legacy instruction (class 3) accepted in DIRTY copies every upper half into the save area, including halves that are zero. `in_ready` then stays low for exactly STALL_CYC cycles while `mode_state` still reads 1. After the stall, the state is PRESERVED (2) and the read port shows the save area.
- R5: A legacy instruction accepted in CLEAN or PRESERVED changes neither the state nor the data, and causes no stall.
- R6: A full-width instruction accepted in PRESERVED causes a restore stall of STALL_CYC cycles with `mode_state` at 2. After the stall, the upper halves equal the save area with the new write applied, and the state is DIRTY.
- R7: A zero-upper (class 4) or zero-all (class 5) instruction accepted in PRESERVED causes a restore stall of STALL_CYC cycles, then leaves every upper half zero and the state CLEAN.
- R8: A zero-upper or zero-all instruction accepted in CLEAN or DIRTY zeroes every upper half and moves the state to CLEAN with no stall.
- R9: A full-width instruction that writes an all-zero upper half keeps the state DIRTY. Only classes 4 and 5 return the machine to CLEAN.
- R10: `stall_cycles` rises by one for each cycle in which a stall holds `in_ready` low, does not change otherwise, and is cleared by reset.
- R11: `lo_zero_we` is high exactly in the cycle in which a zero-all instruction is accepted, and never for any other class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction class is offered |
| in_ready | output | 1 | Block can accept; low during a save or restore stall |
| in_cls | input | 3 | Class: 0 other, 1 half-width wide, 2 full-width wide, 3 legacy narrow, 4 zero-upper, 5 zero-all |
| in_dst | input | $clog2(NREG) | Destination register of a full-width write |
| in_upper | input | UPPER_W | Upper-half value written by a full-width instruction |
| rd_idx | input | $clog2(NREG) | Register selected on the read port |
| rd_upper | output | UPPER_W | Upper half of `rd_idx`; shows the save area while `mode_state` is 2 |
| mode_state | output | 2 | 0 CLEAN, 1 DIRTY, 2 PRESERVED |
| stall_cycles | output | METER_W | Saturating count of stalled cycles |
| lo_zero_we | output | 1 | Strobe to clear all lower halves |

## Verification
The hardest case to reach is a register whose live upper half differs from its saved copy when a restore completes. This case shows whether the restore brings back the saved data before the pending write is applied. To reach it, the stimulus fills one register, forces a save with a legacy instruction, and then leaves PRESERVED with a full-width write to a different register. It then reads both registers. The zero-all exit from PRESERVED is reached in a similar way: a save is forced first, and the bench then checks that the restore stall still happens even though the result is all zeros.

// File: rtl/wut_pkg.sv
package wut_pkg;

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_V128   = 3'd1,
        CLS_V256   = 3'd2,
        CLS_LEGACY = 3'd3,
        CLS_ZUP    = 3'd4,
        CLS_ZALL   = 3'd5
    } icls_e;

    typedef enum logic [1:0] {
        MODE_CLEAN = 2'd0,
        MODE_DIRTY = 2'd1,
        MODE_KEPT  = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        PH_CLEAN,
        PH_DIRTY,
        PH_KEPT,
        PH_SAVE,
        PH_RESTORE
    } phase_e;

endpackage

// File: rtl/wut_fsm.sv
module wut_fsm
    import wut_pkg::*;
#(
    parameter int STALL_CYC = 70
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       acc,
    input  logic [2:0] cls,
    output logic       ready,
    output logic [1:0] mode,
    output logic       stalling,
    output logic       do_wr,
    output logic       do_zero,
    output logic       do_save,
    output logic       do_latch,
    output logic       restore_wr,
    output logic       restore_zero
);
    localparam int CNT_W = $clog2(STALL_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STALL_CYC - 1);

    phase_e         ph, ph_n, tgt, tgt_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    icls_e          c;

    assign c = icls_e'(cls);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_CLEAN;
            tgt <= PH_CLEAN;
            cnt <= '0;
        end else begin
            ph  <= ph_n;
            tgt <= tgt_n;
            cnt <= cnt_n;
        end
    end

    // next state and transition strobes
    always_comb begin
        ph_n         = ph;
        tgt_n        = tgt;
        cnt_n        = cnt;
        do_wr        = 1'b0;
        do_zero      = 1'b0;
        do_save      = 1'b0;
        do_latch     = 1'b0;
        restore_wr   = 1'b0;
        restore_zero = 1'b0;
        unique case (ph)
            PH_CLEAN: begin
                if (acc) begin
                    case (c)
                        CLS_V256: begin
                            do_wr = 1'b1;
                            ph_n  = PH_DIRTY;
                        end
                        CLS_ZUP, CLS_ZALL: do_zero = 1'b1;
                        default: ;
                    endcase
                end
            end
            PH_DIRTY: begin
                if (acc) begin
                    case (c)
                        CLS_V256: do_wr = 1'b1;
                        CLS_LEGACY: begin
                            do_save = 1'b1;
                            ph_n    = PH_SAVE;
                            cnt_n   = CNT_LOAD;
                        end
                        CLS_ZUP, CLS_ZALL: begin
                            do_zero = 1'b1;
                            ph_n    = PH_CLEAN;
                        end
                        default: ;
                    endcase
                end
            end
            PH_KEPT: begin
                if (acc) begin
                    case (c)
                        CLS_V256: begin
                            do_latch = 1'b1;
                            ph_n     = PH_RESTORE;
                            tgt_n    = PH_DIRTY;
                            cnt_n    = CNT_LOAD;
                        end
                        CLS_ZUP, CLS_ZALL: begin
                            ph_n  = PH_RESTORE;
                            tgt_n = PH_CLEAN;
                            cnt_n = CNT_LOAD;
                        end
                        default: ;
                    endcase
                end
            end
            PH_SAVE: begin
                if (cnt == '0) ph_n = PH_KEPT;
                else           cnt_n = cnt - 1'b1;
            end
            PH_RESTORE: begin
                if (cnt == '0) begin
                    ph_n         = tgt;
                    restore_wr   = (tgt == PH_DIRTY);
                    restore_zero = (tgt == PH_CLEAN);
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            default: ph_n = PH_CLEAN;
        endcase
    end

    // outputs
    always_comb begin
        ready    = 1'b0;
        stalling = 1'b0;
        mode     = MODE_CLEAN;
        unique case (ph)
            PH_CLEAN:   begin ready = 1'b1; mode = MODE_CLEAN; end
            PH_DIRTY:   begin ready = 1'b1; mode = MODE_DIRTY; end
            PH_KEPT:    begin ready = 1'b1; mode = MODE_KEPT;  end
            PH_SAVE:    begin stalling = 1'b1; mode = MODE_DIRTY; end
            PH_RESTORE: begin stalling = 1'b1; mode = MODE_KEPT;  end
            default:    mode = MODE_CLEAN;
        endcase
    end

endmodule

// File: rtl/wut_upper_file.sv
module wut_upper_file #(
    parameter int NREG    = 16,
    parameter int UPPER_W = 128,
    localparam int IDX_W  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               do_wr,
    input  logic               do_zero,
    input  logic               do_save,
    input  logic               do_latch,
    input  logic               restore_wr,
    input  logic               restore_zero,
    input  logic [IDX_W-1:0]   wr_dst,
    input  logic [UPPER_W-1:0] wr_data,
    input  logic               show_save,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [UPPER_W-1:0] rd_data
);
    logic [UPPER_W-1:0] live  [NREG];
    logic [UPPER_W-1:0] saved [NREG];
    logic [IDX_W-1:0]   pend_dst;
    logic [UPPER_W-1:0] pend_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_dst  <= '0;
            pend_data <= '0;
        end else if (do_latch) begin
            pend_dst  <= wr_dst;
            pend_data <= wr_data;
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                live[i]  <= '0;
                saved[i] <= '0;
            end else begin
                if (do_save) saved[i] <= live[i];
                if (do_zero || restore_zero)
                    live[i] <= '0;
                else if (restore_wr)
                    live[i] <= (pend_dst == IDX_W'(i)) ? pend_data : saved[i];
                else if (do_wr && wr_dst == IDX_W'(i))
                    live[i] <= wr_data;
            end
        end
    end

    assign rd_data = show_save ? saved[rd_idx] : live[rd_idx];

endmodule

// File: rtl/wut_stall_meter.sv
module wut_stall_meter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)                      count <= '0;
        else if (tick && count != '1) count <= count + 1'b1;
    end
endmodule

// File: rtl/wide_upper_tracker.sv
module wide_upper_tracker
    import wut_pkg::*;
#(
    parameter int NREG      = 16,
    parameter int UPPER_W   = 128,
    parameter int STALL_CYC = 70,
    parameter int METER_W   = 32,
    localparam int IDX_W    = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [2:0]         in_cls,
    input  logic [IDX_W-1:0]   in_dst,
    input  logic [UPPER_W-1:0] in_upper,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [UPPER_W-1:0] rd_upper,
    output logic [1:0]         mode_state,
    output logic [METER_W-1:0] stall_cycles,
    output logic               lo_zero_we
);
    logic acc, stalling;
    logic do_wr, do_zero, do_save, do_latch, restore_wr, restore_zero;

    assign acc        = in_valid && in_ready;
    assign lo_zero_we = acc && (icls_e'(in_cls) == CLS_ZALL);

    wut_fsm #(.STALL_CYC(STALL_CYC)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .acc          (acc),
        .cls          (in_cls),
        .ready        (in_ready),
        .mode         (mode_state),
        .stalling     (stalling),
        .do_wr        (do_wr),
        .do_zero      (do_zero),
        .do_save      (do_save),
        .do_latch     (do_latch),
        .restore_wr   (restore_wr),
        .restore_zero (restore_zero)
    );

    wut_upper_file #(.NREG(NREG), .UPPER_W(UPPER_W)) u_file (
        .clk          (clk),
        .rst          (rst),
        .do_wr        (do_wr),
        .do_zero      (do_zero),
        .do_save      (do_save),
        .do_latch     (do_latch),
        .restore_wr   (restore_wr),
        .restore_zero (restore_zero),
        .wr_dst       (in_dst),
        .wr_data      (in_upper),
        .show_save    (mode_state == MODE_KEPT),
        .rd_idx       (rd_idx),
        .rd_data      (rd_upper)
    );

    wut_stall_meter #(.W(METER_W)) u_meter (
        .clk   (clk),
        .rst   (rst),
        .tick  (stalling),
        .count (stall_cycles)
    );

endmodule

// File: rtl/wut_checker.sv
module wut_checker #(
    parameter int METER_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic [2:0]         in_cls,
    input logic [1:0]         mode_state,
    input logic [METER_W-1:0] stall_cycles,
    input logic               lo_zero_we
);
    logic acc;
    assign acc = in_valid && in_ready;

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode_state != 2'd3); // R1
    AST_V256_TO_DIRTY: assert property (@(posedge clk) disable iff (rst)
        (acc && in_cls == 3'd2 && mode_state != 2'd2) |=> (mode_state == 2'd1 && in_ready)); // R2
    AST_V128_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (acc && in_cls == 3'd1) |=> (in_ready && mode_state == $past(mode_state))); // R3
    AST_SAVE_STALLS: assert property (@(posedge clk) disable iff (rst)
        (acc && in_cls == 3'd3 && mode_state == 2'd1) |=> (!in_ready && mode_state == 2'd1)); // R4
    AST_LEGACY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (acc && in_cls == 3'd3 && mode_state != 2'd1) |=> (in_ready && mode_state == $past(mode_state))); // R5
    AST_RESTORE_STALLS: assert property (@(posedge clk) disable iff (rst)
        (acc && mode_state == 2'd2 && (in_cls == 3'd2 || in_cls == 3'd4 || in_cls == 3'd5))
        |=> (!in_ready && mode_state == 2'd2)); // R6
    AST_ZERO_FREE: assert property (@(posedge clk) disable iff (rst)
        (acc && (in_cls == 3'd4 || in_cls == 3'd5) && mode_state != 2'd2) |=> (in_ready && mode_state == 2'd0)); // R8
    AST_METER_STILL: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> $stable(stall_cycles)); // R10
    AST_METER_STEP: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && stall_cycles != '1) |=> (stall_cycles == $past(stall_cycles) + 1'b1)); // R10
    AST_ZALL_STROBE_EXIT: assert property (@(posedge clk) disable iff (rst)
        lo_zero_we |=> (mode_state == 2'd0 || !in_ready)); // R11

endmodule

bind wide_upper_tracker wut_checker #(.METER_W(METER_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_cls       (in_cls),
    .mode_state   (mode_state),
    .stall_cycles (stall_cycles),
    .lo_zero_we   (lo_zero_we)
);

// File: tb/wide_upper_tracker_bench.sv
module wide_upper_tracker_bench;
    localparam int STALL = 70;
    localparam int NREG  = 16;
    localparam int UW    = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [2:0]    in_cls = '0;
    logic [3:0]    in_dst = '0;
    logic [UW-1:0] in_upper = '0;
    logic [3:0]    rd_idx = '0;
    logic [UW-1:0] rd_upper;
    logic [1:0]    mode_state;
    logic [31:0]   stall_cycles;
    logic          lo_zero_we;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    wide_upper_tracker #(.NREG(NREG), .UPPER_W(UW), .STALL_CYC(STALL), .METER_W(32)) u_wide_upper_tracker (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_dst(in_dst), .in_upper(in_upper),
        .rd_idx(rd_idx), .rd_upper(rd_upper), .mode_state(mode_state),
        .stall_cycles(stall_cycles), .lo_zero_we(lo_zero_we)
    );

    typedef struct packed {
        logic [2:0] cls;
        logic [3:0] dst;
        logic [7:0] dat;
        logic [1:0] md;
        logic       stl;
        logic [3:0] chk;
        logic [7:0] ex;
        logic [3:0] rq;
    } row_t;

    // cls, dst, data, expected mode, stalls?, read reg, expected byte, requirement
    localparam row_t TBL [18] = '{
        '{3'd2, 4'd3, 8'hA5, 2'd1, 1'b0, 4'd3, 8'hA5, 4'd2},  // R2 clean -> dirty
        '{3'd1, 4'd4, 8'h77, 2'd1, 1'b0, 4'd3, 8'hA5, 4'd3},  // R3 half-width in dirty
        '{3'd3, 4'd0, 8'h00, 2'd2, 1'b1, 4'd3, 8'hA5, 4'd4},  // R4 save
        '{3'd3, 4'd0, 8'h00, 2'd2, 1'b0, 4'd3, 8'hA5, 4'd5},  // R5 legacy in preserved
        '{3'd1, 4'd0, 8'h00, 2'd2, 1'b0, 4'd3, 8'hA5, 4'd3},  // R3 half-width in preserved
        '{3'd2, 4'd5, 8'h3C, 2'd1, 1'b1, 4'd5, 8'h3C, 4'd6},  // R6 restore + write
        '{3'd1, 4'd0, 8'h00, 2'd1, 1'b0, 4'd3, 8'hA5, 4'd6},  // R6 other reg restored
        '{3'd4, 4'd0, 8'h00, 2'd0, 1'b0, 4'd3, 8'h00, 4'd8},  // R8 zero-upper from dirty
        '{3'd3, 4'd0, 8'h00, 2'd0, 1'b0, 4'd3, 8'h00, 4'd5},  // R5 legacy in clean
        '{3'd2, 4'd0, 8'h00, 2'd1, 1'b0, 4'd0, 8'h00, 4'd9},  // R9 zero data still dirty
        '{3'd2, 4'd0, 8'h00, 2'd1, 1'b0, 4'd0, 8'h00, 4'd9},  // R9
        '{3'd3, 4'd0, 8'h00, 2'd2, 1'b1, 4'd0, 8'h00, 4'd4},  // R4 zeros still saved
        '{3'd5, 4'd0, 8'h00, 2'd0, 1'b1, 4'd5, 8'h00, 4'd7},  // R7 zero-all from preserved
        '{3'd2, 4'd1, 8'hFF, 2'd1, 1'b0, 4'd1, 8'hFF, 4'd2},  // R2
        '{3'd5, 4'd0, 8'h00, 2'd0, 1'b0, 4'd1, 8'h00, 4'd8},  // R8 zero-all from dirty
        '{3'd2, 4'd6, 8'h5A, 2'd1, 1'b0, 4'd6, 8'h5A, 4'd2},  // R2
        '{3'd3, 4'd0, 8'h00, 2'd2, 1'b1, 4'd6, 8'h5A, 4'd4},  // R4
        '{3'd4, 4'd0, 8'h00, 2'd0, 1'b1, 4'd6, 8'h00, 4'd7}   // R7 zero-upper from preserved
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // issue one class at a negedge; returns stall length and strobe seen
    task automatic issue(input logic [2:0] cls, input logic [3:0] dst, input logic [7:0] dat,
                         output int stalls, output logic zw);
        @(negedge clk);
        in_valid = 1'b1;
        in_cls   = cls;
        in_dst   = dst;
        in_upper = {16{dat}};
        #1 zw = lo_zero_we;
        @(negedge clk);
        in_valid = 1'b0;
        in_cls   = 3'd0;
        stalls   = 0;
        while (!in_ready && stalls < 1000) begin
            stalls++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int st;
        logic zw;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd_idx = 4'd7;
        #1;
        check(mode_state == 2'd0, "R1", "reset mode", 128'(mode_state), 0);
        check(in_ready == 1'b1, "R1", "reset ready", 128'(in_ready), 1);
        check(stall_cycles == 0, "R1", "reset meter", 128'(stall_cycles), 0);
        check(rd_upper == '0, "R1", "reset upper", rd_upper, 0);

        for (int i = 0; i < 18; i++) begin
            string rq;
            rq = $sformatf("R%0d row %0d", TBL[i].rq, i);
            issue(TBL[i].cls, TBL[i].dst, TBL[i].dat, st, zw);
            rd_idx = TBL[i].chk;
            #1;
            check(mode_state == TBL[i].md, rq, "mode", 128'(mode_state), 128'(TBL[i].md));
            check(st == (TBL[i].stl ? STALL : 0), rq, "stall length", 128'(st),
                  128'(TBL[i].stl ? STALL : 0));
            check(rd_upper == {16{TBL[i].ex}}, rq, "upper", rd_upper, {16{TBL[i].ex}});
            check(zw == (TBL[i].cls == 3'd5), "R11", "zero-all strobe", 128'(zw),
                  128'(TBL[i].cls == 3'd5));
        end

        // R4: mode during save stall reads DIRTY, ready low
        issue(3'd2, 4'd2, 8'h11, st, zw);
        @(negedge clk);
        in_valid = 1'b1; in_cls = 3'd3;
        @(negedge clk);
        in_valid = 1'b0; in_cls = 3'd0;
        #1;
        check(in_ready == 1'b0, "R4", "ready in save", 128'(in_ready), 0);
        check(mode_state == 2'd1, "R4", "mode in save", 128'(mode_state), 1);
        st = 1;
        while (!in_ready && st < 1000) begin @(negedge clk); if (!in_ready) st++; end
        rd_idx = 4'd2;
        #1;
        check(st == STALL, "R4", "save length", 128'(st), 128'(STALL));
        check(rd_upper == {16{8'h11}}, "R4", "saved copy", rd_upper, {16{8'h11}});
        // R6: write r2 again on leaving preserved
        issue(3'd2, 4'd2, 8'h22, st, zw);
        #1;
        check(rd_upper == {16{8'h22}}, "R6", "restore write", rd_upper, {16{8'h22}});
        check(mode_state == 2'd1, "R6", "restore mode", 128'(mode_state), 1);

        // R10: 8 stalls of STALL cycles so far
        check(stall_cycles == 32'(8 * STALL), "R10", "meter total", 128'(stall_cycles),
              128'(8 * STALL));

        // R10 / R1: reset clears
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        check(stall_cycles == 0, "R10", "meter after reset", 128'(stall_cycles), 0);
        check(mode_state == 2'd0, "R1", "mode after reset", 128'(mode_state), 0);
        check(rd_upper == '0, "R1", "upper after reset", rd_upper, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule